// File: doc/BRIEF.md
# Output Compare Reference Generator

This block is a single timer channel configured for output. Each cycle it compares the timer's shared counter value against its own active compare value. It then updates a registered reference output according to a 3-bit mode selector. The modes cover hold, set on match, clear on match, toggle on match, forced inactive, forced active, and two pulse-width modes of opposite sense. Each match that the surrounding counter logic qualifies also raises a sticky match flag, which software clears.

The compare value can be written directly or through a buffer. The buffered path loads the active value only at the timer's update event. An external clear input can also pull the reference inactive. When clearing is enabled, one pulse on that input keeps the reference inactive until the next update event.

Top module: `oc_ref_gen`

## Requirements
- R1: After reset, `oc_ref` and `match_flag` are 0 and the active compare value is 0.
- R2: With `mode` = 0, the reference keeps its value whatever the comparison result.
- R3: With `mode` = 1, a match (`cnt` equal to the active compare value) makes `oc_ref` 1 on the next clock. With `mode` = 2, a match makes it 0. Without a match the reference keeps its value.
- R4: With `mode` = 3, each cycle that matches inverts `oc_ref` on the next clock.
- R5: `mode` = 4 drives `oc_ref` to 0 and `mode` = 5 drives it to 1 on the next clock, regardless of the comparison.
- R6: With `mode` = 6, the next `oc_ref` is 1 when `cnt_down` = 0 and `cnt` < compare. It is also 1 when `cnt_down` = 1 and `cnt` <= compare. Otherwise it is 0.
- R7: With `mode` = 7, the next `oc_ref` is the complement of the mode 6 result for the same inputs.
- R8: When `preload_en` = 0, a compare write (`cmp_wr`) becomes active on the next clock. When `preload_en` = 1, the write is only buffered, and the buffer becomes active at the next clock where `upd_evt` = 1.
- R9: When `clear_en` = 1, an `ext_clr` pulse drives `oc_ref` to 0 and holds it there in every mode until a cycle with `upd_evt` = 1. The hold releases on the clock after that cycle. When `clear_en` = 0, `ext_clr` has no effect.
- R10: `match_flag` goes to 1 on the clock after a cycle where `cnt` matches and `match_qual` = 1. A match with `match_qual` = 0 does not set it. `flag_clr` clears it, but a qualified match in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | Counter direction, 1 = counting down |
| match_qual | input | 1 | Allows a match to set the flag (center-aligned direction gating) |
| upd_evt | input | 1 | Timer update event |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value written |
| mode | input | 3 | Reference mode selector |
| preload_en | input | 1 | Buffer compare writes until update |
| clear_en | input | 1 | Enables the external clear |
| ext_clr | input | 1 | External clear request |
| flag_clr | input | 1 | Software clear of the match flag |
| oc_ref | output | 1 | Reference output |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench targets the boundary between `cnt` < compare and `cnt` = compare in both counting directions. A design with an off-by-one comparison would produce pulses one count too wide or too narrow. Compare writes are issued with and without buffering, and some coincide with update events. A design that loads the buffer at the wrong moment would switch the pulse-width threshold early or late. External clear pulses are placed away from update events, so a design that does not hold the clear would let the reference recover too soon. Flag clears are issued in the same cycle as qualified matches, which shows whether set takes priority over clear.

// File: rtl/oc_ref_gen.sv
module oc_ref_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic             match_qual,
  input  logic             upd_evt,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [2:0]       mode,
  input  logic             preload_en,
  input  logic             clear_en,
  input  logic             ext_clr,
  input  logic             flag_clr,
  output logic             oc_ref,
  output logic             match_flag
);

  typedef enum logic [2:0] {
    M_FROZEN = 3'd0, M_SET = 3'd1, M_CLR = 3'd2, M_TOGGLE = 3'd3,
    M_LOW = 3'd4, M_HIGH = 3'd5, M_PWM = 3'd6, M_PWM_N = 3'd7
  } ref_mode_e;

  logic [CNT_W-1:0] cmp_act, cmp_buf;
  logic             clr_hold;
  logic             hit, below, clr_now, ref_nxt;

  assign hit     = (cnt == cmp_act);
  assign below   = cnt_down ? (cnt <= cmp_act) : (cnt < cmp_act);
  assign clr_now = clear_en & (ext_clr | clr_hold);

  always_comb begin
    ref_nxt = oc_ref;
    case (ref_mode_e'(mode))
      M_SET:    if (hit) ref_nxt = 1'b1;
      M_CLR:    if (hit) ref_nxt = 1'b0;
      M_TOGGLE: if (hit) ref_nxt = ~oc_ref;
      M_LOW:    ref_nxt = 1'b0;
      M_HIGH:   ref_nxt = 1'b1;
      M_PWM:    ref_nxt = below;
      M_PWM_N:  ref_nxt = ~below;
      default:  ref_nxt = oc_ref;
    endcase
    if (clr_now) ref_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
      cmp_buf <= '0;
    end else begin
      if (cmp_wr) cmp_buf <= cmp_wdata;
      if (cmp_wr && !preload_en) cmp_act <= cmp_wdata;
      else if (upd_evt)          cmp_act <= cmp_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_hold   <= 1'b0;
      oc_ref     <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (clear_en && ext_clr) clr_hold <= 1'b1;
      else if (upd_evt)        clr_hold <= 1'b0;
      oc_ref <= ref_nxt;
      if (hit && match_qual) match_flag <= 1'b1;
      else if (flag_clr)     match_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/oc_ref_gen_sva.sv
module oc_ref_gen_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_act,
  input logic             clr_hold,
  input logic             match_qual,
  input logic [2:0]       mode,
  input logic             clear_en,
  input logic             ext_clr,
  input logic             flag_clr,
  input logic             oc_ref,
  input logic             match_flag
);

  logic clearing;
  assign clearing = clear_en & (ext_clr | clr_hold);

  a_r2_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !clearing) |=> $stable(oc_ref));

  a_r5_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |=> !oc_ref);

  a_r5_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && !clearing) |=> oc_ref);

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_en && ext_clr) |=> !oc_ref);

  a_r10_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (match_qual && cnt == cmp_act) |=> match_flag);

  a_r10_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(match_qual && cnt == cmp_act)) |=> !match_flag);

endmodule

bind oc_ref_gen oc_ref_gen_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_act(cmp_act), .clr_hold(clr_hold),
  .match_qual(match_qual), .mode(mode), .clear_en(clear_en), .ext_clr(ext_clr),
  .flag_clr(flag_clr), .oc_ref(oc_ref), .match_flag(match_flag)
);

// File: tb/oc_ref_gen_test.sv
module oc_ref_gen_test;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cnt = '0, cmp_wdata = '0;
  logic cnt_down = 0, match_qual = 0, upd_evt = 0, cmp_wr = 0;
  logic [2:0] mode = 3'd0;
  logic preload_en = 0, clear_en = 0, ext_clr = 0, flag_clr = 0;
  logic oc_ref, match_flag;

  int checks = 0, errors = 0, cycles = 0;
  logic m_ref = 0, m_flag = 0, m_hold = 0;
  logic [W-1:0] m_act = '0, m_buf = '0;

  always #5 clk = ~clk;

  oc_ref_gen #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down), .match_qual(match_qual),
    .upd_evt(upd_evt), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .mode(mode),
    .preload_en(preload_en), .clear_en(clear_en), .ext_clr(ext_clr), .flag_clr(flag_clr),
    .oc_ref(oc_ref), .match_flag(match_flag)
  );

  function automatic logic exp_ref();
    logic hit, below, r;
    hit = (cnt == m_act);
    below = cnt_down ? (cnt <= m_act) : (cnt < m_act);
    r = m_ref;
    case (mode)
      3'd1: if (hit) r = 1'b1;
      3'd2: if (hit) r = 1'b0;
      3'd3: if (hit) r = ~m_ref;
      3'd4: r = 1'b0;
      3'd5: r = 1'b1;
      3'd6: r = below;
      3'd7: r = ~below;
      default: r = m_ref;
    endcase
    if (clear_en && (ext_clr || m_hold)) r = 1'b0;
    return r;
  endfunction

  function automatic string auto_tag();
    if (clear_en && (ext_clr || m_hold)) return "R9";
    case (mode)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag = "");
    logic n_ref, n_flag;
    string t;
    t = (tag == "") ? auto_tag() : tag;
    n_ref  = exp_ref();
    n_flag = (match_qual && cnt == m_act) ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    if (clear_en && ext_clr) m_hold = 1'b1; else if (upd_evt) m_hold = 1'b0;
    if (cmp_wr && !preload_en) m_act = cmp_wdata; else if (upd_evt) m_act = m_buf;
    if (cmp_wr) m_buf = cmp_wdata;
    m_ref = n_ref;
    m_flag = n_flag;
    @(posedge clk); #1;
    check(t, oc_ref, m_ref, "oc_ref");
    check("R10", match_flag, m_flag, "match_flag");
    {upd_evt, cmp_wr, ext_clr, flag_clr} = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    check("R1", oc_ref, 1'b0, "reset oc_ref");
    check("R1", match_flag, 1'b0, "reset match_flag");
    rst_n = 1;
    // R1: active compare 0 -> cnt 0 matches
    cnt = 0; match_qual = 1; step("R1");

    // R8: unbuffered write is live next clock
    mode = 3'd6; cnt = 10; match_qual = 0;
    cmp_wr = 1; cmp_wdata = 20; step("R8");
    step("R8");
    check("R8", oc_ref, 1'b1, "unbuffered threshold");
    // R8: buffered write waits for update
    preload_en = 1; cmp_wr = 1; cmp_wdata = 5; step("R8");
    step("R8");
    check("R8", oc_ref, 1'b1, "buffered write not yet live");
    upd_evt = 1; step("R8");
    step("R8");
    check("R8", oc_ref, 1'b0, "buffered write live after update");
    preload_en = 0;

    // R6 boundary both directions, compare = 5
    cnt = 4; step("R6"); check("R6", oc_ref, 1'b1, "up below");
    cnt = 5; step("R6"); check("R6", oc_ref, 1'b0, "up equal");
    cnt_down = 1; cnt = 5; step("R6"); check("R6", oc_ref, 1'b1, "down equal");
    cnt = 6; step("R6"); check("R6", oc_ref, 1'b0, "down above");
    // R7 complement
    mode = 3'd7; cnt = 5; step("R7"); check("R7", oc_ref, 1'b0, "inverted down equal");
    cnt_down = 0; step("R7"); check("R7", oc_ref, 1'b1, "inverted up equal");

    // R4 toggle on consecutive matches
    mode = 3'd3; cnt = 5; step("R4"); step("R4"); step("R4");
    cnt = 7; step("R4");

    // R3 set / clear
    mode = 3'd2; cnt = 5; step("R3");
    mode = 3'd1; cnt = 9; step("R3"); cnt = 5; step("R3");
    // R2 frozen
    mode = 3'd0; step("R2"); cnt = 1; step("R2");

    // R9 clear holds until update; disabled clear ignored
    mode = 3'd5; step("R5");
    clear_en = 0; ext_clr = 1; step("R9"); check("R9", oc_ref, 1'b1, "clear disabled");
    clear_en = 1; ext_clr = 1; step("R9");
    step("R9"); step("R9"); check("R9", oc_ref, 1'b0, "held inactive");
    upd_evt = 1; step("R9");
    step("R9"); check("R9", oc_ref, 1'b1, "released after update");
    clear_en = 0;

    // R10 qualifier and set-over-clear
    cnt = 5; match_qual = 0; flag_clr = 1; step("R10");
    check("R10", match_flag, 1'b0, "unqualified match ignored");
    match_qual = 1; flag_clr = 1; step("R10");
    check("R10", match_flag, 1'b1, "set wins over clear");
    match_qual = 0; cnt = 2; flag_clr = 1; step("R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) mode = 3'($urandom_range(0, 7));
      cnt = W'($urandom_range(0, 12));
      cnt_down = 1'($urandom_range(0, 1));
      match_qual = 1'($urandom_range(0, 1));
      upd_evt = ($urandom_range(0, 7) == 0);
      cmp_wr = ($urandom_range(0, 7) == 0);
      cmp_wdata = W'($urandom_range(0, 12));
      if ($urandom_range(0, 31) == 0) preload_en = ~preload_en;
      if ($urandom_range(0, 31) == 0) clear_en = ~clear_en;
      ext_clr = ($urandom_range(0, 19) == 0);
      flag_clr = ($urandom_range(0, 5) == 0);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule